// File: doc/BRIEF.md
# Touchscreen Coordinate Change Monitor

This block sits in the I/O region at the top of a 24-bit, word-organised address space. It has three word locations: a screen-flash control word, the live touch X coordinate and the live touch Y coordinate. A CPU reaches them over a plain read/write bus with an address, a write data word, separate read and write strobes, and a registered read data word.

A small hardware poller also watches the two coordinate inputs. Each time the `tick` input is accepted, the poller latches both coordinates. In the next cycle it compares them with the copies it kept from its last update. If either coordinate differs, it drives a one-cycle `flash` pulse and replaces the kept copies. If both match, it does nothing and goes back to waiting. A nonzero write to the flash word also produces a one-cycle flash pulse.

The poller has three states. It rests in WAIT. It moves from WAIT to CHECK when `tick` is high, which is the *capture* transition. From CHECK it moves to REFRESH when a coordinate differs, which is the *mismatch* transition. From CHECK it returns to WAIT when both coordinates match, which is the *match* transition. From REFRESH it always returns to WAIT, which is the *commit* transition.

Top module: `touch_mon_top`

## Requirements
- R1: While reset is asserted, and right after it, `flash` is low and `bus_rdata` is zero. The kept coordinate copies are cleared to zero, so a tick with both coordinates at zero produces no flash.
- R2: The X word is at 0xFFFFF0 and the Y word is at 0xFFFFF4. Decoding compares all 24 address bits. A read of either word returns that coordinate input, as seen at the read edge and zero-extended, on `bus_rdata` in the following cycle.
- R3: A read of the flash word at 0xFFFFEC returns the `flash` level seen at the read edge in bit 0, with all other bits zero.
- R4: A read of any other address returns zero. A write to any address other than 0xFFFFEC, including the X and Y words, has no effect on `flash`.
- R5: A write of a nonzero data word to 0xFFFFEC makes `flash` high for exactly the next cycle. A write of zero to that word has no effect.
- R6: A `tick` seen high in WAIT latches both coordinates. The comparison is made in the following cycle, in CHECK.
- R7: If either latched coordinate differs from its kept copy, `flash` is high during the second cycle after the tick edge, for one cycle. The kept copies then take the latched values.
- R8: If both latched coordinates equal the kept copies, the poll produces no flash and the poller returns to WAIT.
- R9: A `tick` that arrives while the poller is in CHECK or REFRESH is ignored. It latches nothing and starts no poll.
- R10: After reset, the first poll with a nonzero coordinate produces a flash.
- R11: In any cycle that follows an edge with no read, `bus_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Poll request, one per poll |
| touch_x | input | COORD_W (12) | Live X coordinate |
| touch_y | input | COORD_W (12) | Live Y coordinate |
| bus_addr | input | ADDR_W (24) | Byte address of the access |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | DATA_W (32) | Read data, one cycle after the read strobe |
| flash | output | 1 | Screen-flash pulse |

## Verification
Each result has a fixed latency. Read data appears one cycle after the read edge. A flash caused by a write appears one cycle after the write edge. A flash caused by a poll appears two cycles after the accepted tick edge, because the tick first moves the poller to CHECK and the flash shows only in REFRESH. The bench drives inputs just after the falling edge and compares `flash` and `bus_rdata` at every falling edge with a behavioural model that it advances on each rising edge. Its directed checks count exactly one, two or three edges after each stimulus, using these same latencies.

// File: rtl/touch_mon_pkg.sv
package touch_mon_pkg;

    typedef enum logic [1:0] {
        PS_WAIT    = 2'd0,
        PS_CHECK   = 2'd1,
        PS_REFRESH = 2'd2
    } poll_state_t;

    localparam int          AXES          = 2;
    localparam logic [23:0] DEF_FLASH_ADR = 24'hFFFFEC;
    localparam logic [23:0] DEF_X_ADR     = 24'hFFFFF0;
    localparam logic [23:0] DEF_Y_ADR     = 24'hFFFFF4;

endpackage

// File: rtl/touch_axis_store.sv
module touch_axis_store #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         capture,
    input  logic         commit,
    input  logic [W-1:0] coord_in,
    output logic         differs
);

    logic [W-1:0] latched_q;
    logic [W-1:0] kept_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latched_q <= '0;
            kept_q    <= '0;
        end else begin
            if (capture) begin
                latched_q <= coord_in;
            end
            if (commit) begin
                kept_q <= latched_q;
            end
        end
    end

    assign differs = (latched_q != kept_q);

endmodule

// File: rtl/touch_poller.sv
module touch_poller
    import touch_mon_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        any_diff,
    output logic        capture,
    output logic        commit,
    output logic        flash_req,
    output poll_state_t state_o
);

    poll_state_t state_q;
    poll_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PS_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PS_WAIT:    if (tick) state_d = PS_CHECK;
            PS_CHECK:   state_d = any_diff ? PS_REFRESH : PS_WAIT;
            PS_REFRESH: state_d = PS_WAIT;
            default:    state_d = PS_WAIT;
        endcase
    end

    always_comb begin
        capture   = 1'b0;
        commit    = 1'b0;
        flash_req = 1'b0;
        unique case (state_q)
            PS_WAIT:    capture = tick;
            PS_CHECK:   ;
            PS_REFRESH: begin
                commit    = 1'b1;
                flash_req = 1'b1;
            end
            default:    ;
        endcase
    end

    assign state_o = state_q;

endmodule

// File: rtl/touch_bus_regs.sv
module touch_bus_regs #(
    parameter int              ADDR_W    = 24,
    parameter int              DATA_W    = 32,
    parameter int              COORD_W   = 12,
    parameter logic [ADDR_W-1:0] FLASH_ADR = 24'hFFFFEC,
    parameter logic [ADDR_W-1:0] X_ADR     = 24'hFFFFF0,
    parameter logic [ADDR_W-1:0] Y_ADR     = 24'hFFFFF4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [COORD_W-1:0] coord_x,
    input  logic [COORD_W-1:0] coord_y,
    input  logic               flash_level,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               wr_flash
);

    localparam int PAD_W = DATA_W - COORD_W;

    logic              hit_flash;
    logic              hit_x;
    logic              hit_y;
    logic [DATA_W-1:0] rdata_d;
    logic [DATA_W-1:0] rdata_q;
    logic              wr_flash_q;

    assign hit_flash = (bus_addr == FLASH_ADR);
    assign hit_x     = (bus_addr == X_ADR);
    assign hit_y     = (bus_addr == Y_ADR);

    always_comb begin
        rdata_d = '0;
        if (bus_rd) begin
            unique case (1'b1)
                hit_flash: rdata_d = {{(DATA_W-1){1'b0}}, flash_level};
                hit_x:     rdata_d = {{PAD_W{1'b0}}, coord_x};
                hit_y:     rdata_d = {{PAD_W{1'b0}}, coord_y};
                default:   rdata_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q    <= '0;
            wr_flash_q <= 1'b0;
        end else begin
            rdata_q    <= rdata_d;
            wr_flash_q <= bus_wr && hit_flash && (bus_wdata != '0);
        end
    end

    assign bus_rdata = rdata_q;
    assign wr_flash  = wr_flash_q;

endmodule

// File: rtl/touch_mon_top.sv
module touch_mon_top
    import touch_mon_pkg::*;
#(
    parameter int              ADDR_W    = 24,
    parameter int              DATA_W    = 32,
    parameter int              COORD_W   = 12,
    parameter logic [ADDR_W-1:0] FLASH_ADR = DEF_FLASH_ADR,
    parameter logic [ADDR_W-1:0] X_ADR     = DEF_X_ADR,
    parameter logic [ADDR_W-1:0] Y_ADR     = DEF_Y_ADR
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic [COORD_W-1:0] touch_x,
    input  logic [COORD_W-1:0] touch_y,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_wr,
    input  logic               bus_rd,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               flash
);

    logic [COORD_W-1:0] axis_in [AXES];
    logic [AXES-1:0]    axis_diff;
    logic               capture;
    logic               commit;
    logic               poll_flash;
    logic               wr_flash;
    poll_state_t        poll_st;

    assign axis_in[0] = touch_x;
    assign axis_in[1] = touch_y;

    for (genvar g = 0; g < AXES; g++) begin : g_axis
        touch_axis_store #(.W(COORD_W)) u_store (
            .clk      (clk),
            .rst_n    (rst_n),
            .capture  (capture),
            .commit   (commit),
            .coord_in (axis_in[g]),
            .differs  (axis_diff[g])
        );
    end

    touch_poller u_poll (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .any_diff  (|axis_diff),
        .capture   (capture),
        .commit    (commit),
        .flash_req (poll_flash),
        .state_o   (poll_st)
    );

    touch_bus_regs #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .COORD_W   (COORD_W),
        .FLASH_ADR (FLASH_ADR),
        .X_ADR     (X_ADR),
        .Y_ADR     (Y_ADR)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_wr      (bus_wr),
        .bus_rd      (bus_rd),
        .coord_x     (touch_x),
        .coord_y     (touch_y),
        .flash_level (flash),
        .bus_rdata   (bus_rdata),
        .wr_flash    (wr_flash)
    );

    assign flash = poll_flash | wr_flash;

endmodule

// File: rtl/touch_mon_chk.sv
module touch_mon_chk
    import touch_mon_pkg::*;
#(
    parameter int              ADDR_W    = 24,
    parameter int              DATA_W    = 32,
    parameter int              COORD_W   = 12,
    parameter logic [ADDR_W-1:0] FLASH_ADR = DEF_FLASH_ADR,
    parameter logic [ADDR_W-1:0] X_ADR     = DEF_X_ADR,
    parameter logic [ADDR_W-1:0] Y_ADR     = DEF_Y_ADR
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [COORD_W-1:0] touch_x,
    input  logic [COORD_W-1:0] touch_y,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [DATA_W-1:0]  bus_rdata,
    input  logic               flash,
    input  poll_state_t        poll_st
);

    localparam int PAD_W = DATA_W - COORD_W;

    logic mapped;
    assign mapped = (bus_addr == FLASH_ADR) || (bus_addr == X_ADR) || (bus_addr == Y_ADR);

    // R5
    wr_flash_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == FLASH_ADR && bus_wdata != '0) |=> flash);

    // R4
    unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !mapped) |=> (bus_rdata == '0));

    // R2
    x_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == X_ADR) |=> (bus_rdata == {{PAD_W{1'b0}}, $past(touch_x)}));

    // R2
    y_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == Y_ADR) |=> (bus_rdata == {{PAD_W{1'b0}}, $past(touch_y)}));

    // R7
    flash_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flash) |-> (poll_st == PS_REFRESH ||
                          $past(bus_wr && bus_addr == FLASH_ADR && bus_wdata != '0)));

    // R9
    busy_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_st != PS_WAIT) |=> (poll_st != PS_CHECK));

    // R11
    idle_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> (bus_rdata == '0));

endmodule

bind touch_mon_top touch_mon_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .COORD_W   (COORD_W),
    .FLASH_ADR (FLASH_ADR),
    .X_ADR     (X_ADR),
    .Y_ADR     (Y_ADR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .touch_x   (touch_x),
    .touch_y   (touch_y),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .flash     (flash),
    .poll_st   (poll_st)
);

// File: tb/touch_mon_top_bench.sv
`timescale 1ns/1ps
module touch_mon_top_bench;

    localparam int          AW   = 24;
    localparam int          DW   = 32;
    localparam int          CW   = 12;
    localparam logic [23:0] A_FL = 24'hFFFFEC;
    localparam logic [23:0] A_X  = 24'hFFFFF0;
    localparam logic [23:0] A_Y  = 24'hFFFFF4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [CW-1:0] tx = '0;
    logic [CW-1:0] ty = '0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic          bus_wr = 1'b0;
    logic          bus_rd = 1'b0;
    logic [DW-1:0] rdata;
    logic          flash;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    touch_mon_top u_touch_mon_top (
        .clk(clk), .rst_n(rst_n), .tick(tick), .touch_x(tx), .touch_y(ty),
        .bus_addr(addr), .bus_wdata(wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_rdata(rdata), .flash(flash)
    );

    task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference: poll phase 0 wait, 1 compare, 2 refresh
    int            m_phase = 0;
    logic [CW-1:0] m_lx = '0, m_ly = '0, m_kx = '0, m_ky = '0;
    bit            m_wr = 1'b0;
    logic [DW-1:0] m_rdata = '0;

    function automatic bit m_flash();
        return (m_phase == 2) || m_wr;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase = 0; m_lx = '0; m_ly = '0; m_kx = '0; m_ky = '0;
            m_wr = 1'b0; m_rdata = '0;
        end else begin
            m_rdata = '0;
            if (bus_rd) begin
                if (addr == A_FL)     m_rdata = DW'(m_flash());
                else if (addr == A_X) m_rdata = DW'(tx);
                else if (addr == A_Y) m_rdata = DW'(ty);
            end
            m_wr = bus_wr && (addr == A_FL) && (wdata != 0);
            if (m_phase == 0) begin
                if (tick) begin m_lx = tx; m_ly = ty; m_phase = 1; end
            end else if (m_phase == 1) begin
                m_phase = ((m_lx != m_kx) || (m_ly != m_ky)) ? 2 : 0;
            end else begin
                m_kx = m_lx; m_ky = m_ly; m_phase = 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R7 flash vs model", DW'(flash), DW'(m_flash()));
            check("R2 rdata vs model", rdata, m_rdata);
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    // tick driven for one edge; returns just after the accepting edge
    task automatic pulse_tick(input logic [CW-1:0] x, input logic [CW-1:0] y);
        tx = x; ty = y; tick = 1'b1;
        step();
        tick = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        repeat (3) step();
        check("R1 flash in reset", DW'(flash), 0);
        check("R1 rdata in reset", rdata, 0);
        rst_n = 1'b1;
        step();
        check("R1 flash after reset", DW'(flash), 0);

        // R1 kept copies cleared: zero sample gives no flash
        pulse_tick(0, 0);
        step(); check("R1 zero first poll", DW'(flash), 0);
        step();
        // R10 nonzero first poll flashes, R6 compare one cycle after capture
        pulse_tick(5, 0);
        check("R6 no flash in compare cycle", DW'(flash), 0);
        step(); check("R10 nonzero poll flash", DW'(flash), 1);
        step(); check("R7 one-cycle pulse", DW'(flash), 0);
        // R8 same values
        pulse_tick(5, 0);
        step(); check("R8 unchanged no flash", DW'(flash), 0);
        step();
        // R7 only Y changes
        pulse_tick(5, 9);
        step(); check("R7 y change flash", DW'(flash), 1);
        step();
        // R9 tick during compare ignored
        pulse_tick(5, 9);
        tx = 7; tick = 1'b1;
        step(); tick = 1'b0;
        check("R9 tick in compare ignored", DW'(flash), 0);
        step(); check("R9 no late poll", DW'(flash), 0);
        pulse_tick(7, 9);
        step(); check("R7 x change flash", DW'(flash), 1);
        step();
        // R9 tick during refresh ignored
        pulse_tick(8, 9);
        tick = 1'b1;
        step(); check("R7 flash before busy tick", DW'(flash), 1);
        step(); tick = 1'b0;
        check("R9 tick in refresh ignored", DW'(flash), 0);
        step(); check("R9 still quiet", DW'(flash), 0);

        // reads
        tx = 12'hABC; ty = 12'h123;
        bus_rd = 1'b1; addr = A_X;
        step(); check("R2 read X", rdata, 32'h00000ABC);
        addr = A_Y;
        step(); check("R2 read Y", rdata, 32'h00000123);
        addr = A_FL;
        step(); check("R3 read flash low", rdata, 0);
        addr = 24'hFFFFE8;
        step(); check("R4 read unmapped", rdata, 0);
        addr = 24'h00FFF0;
        step(); check("R4 read partial match", rdata, 0);
        bus_rd = 1'b0; addr = A_X;
        step(); check("R11 no read zero", rdata, 0);

        // writes
        bus_wr = 1'b1; addr = A_FL; wdata = 32'h1;
        step(); check("R5 write flash", DW'(flash), 1);
        bus_wr = 1'b0; bus_rd = 1'b1;
        step(); check("R3 read flash high", rdata, 1);
        check("R5 write pulse ends", DW'(flash), 0);
        bus_rd = 1'b0;
        bus_wr = 1'b1; wdata = 32'h0;
        step(); check("R5 zero write ignored", DW'(flash), 0);
        addr = A_X; wdata = 32'hFFFF_FFFF;
        step(); check("R4 write X ignored", DW'(flash), 0);
        addr = 24'hFFFFF8;
        step(); check("R4 write unmapped ignored", DW'(flash), 0);
        bus_wr = 1'b0; wdata = '0;
        step();

        // mixed traffic against the model
        r = 32'h1234_5678;
        for (int i = 0; i < 4000; i++) begin
            r ^= r << 13; r ^= r >> 17; r ^= r << 5;
            tick   = r[0] & r[1];
            tx     = CW'(r[3:2]);
            ty     = CW'(r[5:4]);
            case (r[8:6])
                3'd0:    addr = A_FL;
                3'd1:    addr = A_X;
                3'd2:    addr = A_Y;
                3'd3:    addr = 24'hFFFFE8;
                3'd4:    addr = 24'hFFFFF8;
                default: addr = 24'h000800;
            endcase
            bus_rd = r[9];
            bus_wr = r[10] & r[11];
            wdata  = r[12] ? 32'h0 : {16'h0, r[31:16]};
            step();
        end
        tick = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0;
        step(); step(); step();

        // R1 reset mid-run clears kept copies
        pulse_tick(3, 3);
        rst_n = 1'b0;
        step(); check("R1 flash held in reset", DW'(flash), 0);
        check("R1 rdata held in reset", rdata, 0);
        rst_n = 1'b1;
        step();
        pulse_tick(0, 0);
        step(); check("R1 cleared copies after reset", DW'(flash), 0);
        step();
        finish_run();
    end

endmodule